// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous host and an asynchronous static RAM that holds 16,384 one-bit words. The RAM has a separate input data pin and output data pin, plus two active-low strobes: chip select and write strobe. The host issues one operation at a time. It raises a request together with a read/write flag, a 14-bit address and a write bit, and it may do so only while the block reports ready. The block then runs the strobe sequence that the RAM needs. For a read it returns the bit on a registered output, marked valid for one cycle.

All timing is counted in whole clock cycles. Each count is derived from a nanosecond limit and the clock period, both given as parameters. Each count is rounded up and is never less than one cycle. With the default 8 ns clock the counts are as follows:

- the read access wait is 2 cycles (15 ns);
- the write strobe pulse is 2 cycles (12 ns);
- the deselect recovery is 1 cycle (8 ns).

During a write, the address and the input data are stable before the write strobe falls. The write strobe rises while chip select is still low. Chip select rises one cycle later. The address and the data do not change until both strobes are high. Between operations chip select is held high so that the RAM sits in its power-down state.

Top module: `async_sram_ctl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released: ready_o=1, mem_ce_no=1, mem_we_no=1 and rvalid_o=0.
- R2: mem_we_no is never low unless mem_ce_no is low. Whenever ready_o is high, mem_ce_no is high.
- R3: A request made while ready_o is low is ignored. It produces no strobe activity, no rvalid_o pulse and no write to memory.
- R4: Write accepted at clock edge E0 (req_i=1, we_i=1, ready_o=1). The strobes follow this cycle sequence:
  - 1 cycle with CE low and WE high;
  - WE_CYC cycles with both strobes low;
  - 1 cycle with CE low and WE high;
  - CE high.
- R5: While mem_ce_no is low, mem_addr_o holds the accepted address. During a write, mem_di_o also holds the accepted data bit while mem_ce_no is low.
- R6: Read accepted at E0 (we_i=0). Timing is as follows:
  - CE is low and WE is high for ACC_CYC cycles;
  - mem_do_i is sampled at the edge that ends that window;
  - rvalid_o is high for exactly one cycle, ACC_CYC cycles after E0, with the sampled bit on rdata_o.
- R7: After CE rises, it stays high for REC_CYC cycles before ready_o returns. A write takes WE_CYC+2+REC_CYC cycles from E0 until ready_o. A read takes ACC_CYC+REC_CYC cycles.
- R8: A read returns the bit most recently written to that address. This holds for both data values, for the lowest and highest addresses, and across an overwrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 14 | Word address |
| wdata_i | input | 1 | Bit to write |
| ready_o | output | 1 | Idle and able to accept a request |
| rdata_o | output | 1 | Registered read bit |
| rvalid_o | output | 1 | One-cycle pulse marking rdata_o |
| mem_addr_o | output | 14 | RAM address |
| mem_ce_no | output | 1 | RAM chip select, active low |
| mem_we_no | output | 1 | RAM write strobe, active low |
| mem_di_o | output | 1 | RAM input data |
| mem_do_i | input | 1 | RAM output data |

## Verification
Each check counts cycles from the accepting edge E0. The bench records the cycle number at that edge and then samples on every following falling edge. At those points it compares the strobe pattern with the table for offset k: for a write, offsets 0 through WE_CYC+2+REC_CYC; for a read, offsets 0 through ACC_CYC+REC_CYC.

A read pushes its expected bit and its due cycle (E0 plus ACC_CYC) into a scoreboard. The monitor pops the entry when rvalid_o appears and checks both values. The RAM model in the bench drives valid data only after ACC_CYC falling edges with CE low and WE high. An early capture therefore returns an unknown value. The model writes only when the overlap of the two strobes ends.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RD_ACCESS,
    ST_RECOVER
  } ctl_state_e;

  // whole clock cycles covering a ns limit, at least one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_io_regs.sv
module sram_io_regs #(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  input  logic              capture_i,
  input  logic              mem_do_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_di_o,
  output logic              rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_di_o   <= 1'b0;
    end else if (accept_i) begin
      mem_addr_o <= addr_i;
      mem_di_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= 1'b0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= mem_do_i;
    end
  end

  p_rvalid_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 14,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_ACCESS_NS   = 15,
  parameter int unsigned T_WE_NS       = 12,
  parameter int unsigned T_RECOVER_NS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  output logic              ready_o,
  output logic              rdata_o,
  output logic              rvalid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_di_o,
  input  logic              mem_do_i
);
  localparam int unsigned ACC_CYC = ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int unsigned WE_CYC  = ns_to_cyc(T_WE_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC = ns_to_cyc(T_RECOVER_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC = (ACC_CYC > WE_CYC)
                                    ? ((ACC_CYC > REC_CYC) ? ACC_CYC : REC_CYC)
                                    : ((WE_CYC > REC_CYC) ? WE_CYC : REC_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  ctl_state_e       state_q, state_d;
  logic             load, accept, capture, tmr_zero;
  logic [CNT_W-1:0] load_val;
  logic             ce_act_d;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .zero_o (tmr_zero)
  );

  sram_io_regs #(.ADDR_W(ADDR_W)) u_io (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .capture_i  (capture),
    .mem_do_i   (mem_do_i),
    .mem_addr_o (mem_addr_o),
    .mem_di_o   (mem_di_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        accept = 1'b1;
        if (we_i) state_d = ST_WR_SETUP;
        else begin
          state_d  = ST_RD_ACCESS;
          load     = 1'b1;
          load_val = CNT_W'(ACC_CYC - 1);
        end
      end
      ST_WR_SETUP: begin
        state_d  = ST_WR_PULSE;
        load     = 1'b1;
        load_val = CNT_W'(WE_CYC - 1);
      end
      ST_WR_PULSE: if (tmr_zero) state_d = ST_WR_HOLD;
      ST_WR_HOLD: begin  // WE back high, CE still low
        state_d  = ST_RECOVER;
        load     = 1'b1;
        load_val = CNT_W'(REC_CYC - 1);
      end
      ST_RD_ACCESS: if (tmr_zero) begin
        capture  = 1'b1;
        state_d  = ST_RECOVER;
        load     = 1'b1;
        load_val = CNT_W'(REC_CYC - 1);
      end
      ST_RECOVER: if (tmr_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ce_act_d = (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
                    (state_d == ST_WR_HOLD)  || (state_d == ST_RD_ACCESS);

  // strobes registered from next state: glitch-free at the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mem_ce_no <= 1'b1;
      mem_we_no <= 1'b1;
    end else begin
      state_q   <= state_d;
      mem_ce_no <= !ce_act_d;
      mem_we_no <= (state_d != ST_WR_PULSE);
    end
  end

  assign ready_o = (state_q == ST_IDLE);

  // checking counters
  logic [CNT_W:0] we_lo_cnt, ce_hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      ce_hi_cnt <= '0;
    end else begin
      we_lo_cnt <= !mem_we_no ? we_lo_cnt + 1'b1 : '0;
      if (!mem_ce_no) ce_hi_cnt <= '0;
      else if (ce_hi_cnt != '1) ce_hi_cnt <= ce_hi_cnt + 1'b1;
    end
  end

  p_we_in_ce_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> !mem_ce_no);
  p_ready_desel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> mem_ce_no);
  p_ce_after_we_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> $past(mem_we_no));
  p_we_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> we_lo_cnt == (CNT_W+1)'(WE_CYC));
  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |=> (mem_ce_no || $stable(mem_addr_o)));
  p_di_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |=> (mem_ce_no || $stable(mem_di_o)));
  p_capture_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |-> (!mem_ce_no && mem_we_no));
  p_recover_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ce_hi_cnt >= (CNT_W+1)'(REC_CYC));
endmodule

// File: tb/async_sram_ctl_test.sv
module async_sram_ctl_test;
  localparam int ACC = 2, WE = 2, REC = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, wd = 1'b0;
  logic [13:0] addr = '0;
  logic ready_o, rdata_o, rvalid_o, ce_n, we_n, di, do_q;
  logic [13:0] maddr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  async_sram_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wd), .ready_o(ready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .mem_addr_o(maddr), .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_di_o(di),
    .mem_do_i(do_q)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // RAM model: write at end of strobe overlap; data valid after ACC read cycles
  logic mem [int];
  logic shadow [int];
  bit prev_wr = 0;
  int rd_cnt = 0;
  always @(negedge clk) begin
    if (prev_wr && !(!ce_n && !we_n)) mem[int'(maddr)] = di;
    prev_wr = !ce_n && !we_n;
    if (!ce_n && we_n) rd_cnt++; else rd_cnt = 0;
    if (!ce_n && we_n && rd_cnt >= ACC)
      do_q = mem.exists(int'(maddr)) ? mem[int'(maddr)] : 1'b0;
    else
      do_q = 1'bx;
  end

  // scoreboard
  logic exp_q[$];
  int   cyc_q[$];
  int   n_rv = 0, n_rd = 0;
  logic [13:0] cur_addr = '0;
  logic cur_di = 1'b0;
  bit   cur_w = 0;

  always @(negedge clk) if (rst_n) begin
    if (rvalid_o) begin
      n_rv++;
      if (exp_q.size() == 0) chk(0, "R3 unexpected rvalid", 1, 0);
      else begin
        automatic logic e = exp_q.pop_front();
        automatic int  ec = cyc_q.pop_front();
        chk(rdata_o === e, "R8 read data", int'(rdata_o), int'(e));
        chk(cyc == ec, "R6 rvalid cycle", cyc, ec);
      end
    end
    if (ready_o && !ce_n) chk(0, "R2 ce low while ready", 0, 1);
    if (!we_n && ce_n) chk(0, "R2 we low without ce", 1, 0);
    if (!ce_n) begin
      chk(maddr == cur_addr, "R5 address held", int'(maddr), int'(cur_addr));
      if (cur_w) chk(di == cur_di, "R5 data held", int'(di), int'(cur_di));
    end
  end

  task automatic issue(input bit w, input logic [13:0] a, input logic d, output int c0);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1'b1; we = w; addr = a; wd = d;
    @(posedge clk); #1;
    c0 = cyc;
    cur_addr = a; cur_di = d; cur_w = w;
    if (w) shadow[int'(a)] = d;
    else begin
      exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 1'b0);
      cyc_q.push_back(c0 + ACC);
      n_rd++;
    end
    @(negedge clk);
    req = 1'b0;
  endtask

  function automatic int pat(input logic c, input logic w, input logic r);
    return {29'd0, c, w, r};
  endfunction

  task automatic trace_write(input int c0);
    for (int k = 0; k <= WE + 2 + REC; k++) begin
      automatic int ep;
      if (k == 0 || k == WE + 1) ep = pat(0, 1, 0);
      else if (k <= WE)          ep = pat(0, 0, 0);
      else if (k < WE + 2 + REC) ep = pat(1, 1, 0);
      else                       ep = pat(1, 1, 1);
      if (k <= WE + 1) chk(pat(ce_n, we_n, ready_o) == ep, "R4 write strobes", pat(ce_n, we_n, ready_o), ep);
      else chk(pat(ce_n, we_n, ready_o) == ep, "R7 write recovery", pat(ce_n, we_n, ready_o), ep);
      if (k < WE + 2 + REC) @(negedge clk);
    end
  endtask

  task automatic trace_read(input int c0);
    for (int k = 0; k <= ACC + REC; k++) begin
      automatic int ep;
      if (k < ACC)            ep = pat(0, 1, 0);
      else if (k < ACC + REC) ep = pat(1, 1, 0);
      else                    ep = pat(1, 1, 1);
      if (k < ACC) chk(pat(ce_n, we_n, ready_o) == ep, "R6 read strobes", pat(ce_n, we_n, ready_o), ep);
      else chk(pat(ce_n, we_n, ready_o) == ep, "R7 read recovery", pat(ce_n, we_n, ready_o), ep);
      if (k < ACC + REC) @(negedge clk);
    end
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    chk(ready_o && ce_n && we_n && !rvalid_o, "R1 in reset",
        pat(ce_n, we_n, ready_o), pat(1, 1, 1));
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_o && ce_n && we_n && !rvalid_o, "R1 after release",
        pat(ce_n, we_n, ready_o), pat(1, 1, 1));

    // R4/R7 write timing, R6 read timing
    issue(1, 14'h2AAA, 1'b1, c0); trace_write(c0);
    issue(0, 14'h2AAA, 1'b0, c0); trace_read(c0);

    // R8 patterns: extremes, both values, overwrite
    issue(1, 14'h0000, 1'b1, c0);
    issue(1, 14'h3FFF, 1'b1, c0);
    issue(1, 14'h1555, 1'b0, c0);
    issue(0, 14'h0000, 1'b0, c0);
    issue(0, 14'h3FFF, 1'b0, c0);
    issue(0, 14'h1555, 1'b0, c0);
    issue(1, 14'h3FFF, 1'b0, c0);
    issue(0, 14'h3FFF, 1'b1, c0);
    issue(0, 14'h0123, 1'b1, c0);

    // R3: requests while busy must be ignored
    issue(1, 14'h0200, 1'b1, c0);
    req = 1'b1; we = 1'b0; addr = 14'h0300; wd = 1'b1;
    repeat (2) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 14'h0200; wd = 1'b0;
    @(negedge clk);
    req = 1'b0;
    while (!ready_o) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk(ce_n && ready_o, "R3 no activity after ignored request", pat(ce_n, we_n, ready_o), pat(1, 1, 1));
    end
    chk(n_rv == n_rd, "R3 rvalid count", n_rv, n_rd);
    issue(0, 14'h0200, 1'b0, c0);
    issue(0, 14'h0300, 1'b0, c0);

    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
    chk(n_rv == n_rd, "R8 read count", n_rv, n_rd);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule